// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the card clock for an SD/MMC host from the host master clock. Software writes a control word that holds a sparse one-hot divider code, a clock-output enable bit and an auto-stop bit. When the auto-stop bit is set, the card clock is parked while the host reports that the card bus is idle. The block drives the card clock pin. It also gives the command and data shifters a one-cycle strobe in every master cycle that holds a card clock rising edge, so those shifters stay in the master clock domain.

Three states control the clock. In `ST_HALT` the clock is held low. In `ST_DIVIDE` a half-period counter toggles a registered divided clock. In `ST_BYPASS` the master clock passes through an enable that is sampled on the falling edge.

The transitions are:
- *start-divide*: from `ST_HALT` to `ST_DIVIDE` when the clock is wanted and the code is not bypass.
- *start-bypass*: from `ST_HALT` to `ST_BYPASS` when the clock is wanted and the code is bypass.
- *park*: from `ST_DIVIDE` to `ST_HALT` at the end of a low phase when the clock is no longer wanted.
- *leave-bypass*: from `ST_BYPASS` to `ST_HALT` when the clock is no longer wanted or the code is no longer bypass.

"Wanted" means that the enable bit is set and that auto-stop is not currently holding the clock off.

Top module: `sdclk_gen`

## Requirements
- R1: After reset, card_clk and rise_stb are low, and they stay low until a control word with the enable bit (bit 8) set is written.
- R2: Divider code bits 0 to 7 select divide by 4, 8, 16, 32, 64, 128, 256 and 512 respectively, and a code of all zeros selects divide by 2. Every divided clock has equal high and low phases of half the divisor, counted in master cycles.
- R3: Code bit 10 alone selects the undivided master clock on card_clk, and rise_stb is then high in every cycle that holds a card clock pulse.
- R4: With parameter USE_DIV1024 set (the default), code bit 16 selects divide by 1024 and wins over every other code bit.
- R5: When several divider bits are set, the largest selected divisor wins. Bit 10 gives the undivided clock only when no divider bit is set.
- R6: While the enable bit is clear, card_clk and rise_stb stay low, whatever the code is.
- R7: With auto-stop (bit 9) and enable both set, the card clock parks low at the end of the current low phase while bus_idle is high. When bus_idle falls, the clock restarts with a rising edge one cycle later.
- R8: Turning the clock off never shortens a phase: a running divided clock finishes its high phase and its full low phase before it parks.
- R9: rise_stb is a one-cycle pulse that starts at the same master edge as each rising edge of the divided clock, and it is low at every other time.
- R10: A write takes effect from the master edge at which it is sampled. Bits of the control word outside bits 0 to 10 and bit 16 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: code bits 0 to 7, 10 and 16; enable bit 8; auto-stop bit 9 |
| bus_idle | input | 1 | High while no command or data transfer uses the card bus |
| card_clk | output | 1 | Card clock |
| rise_stb | output | 1 | High in each master cycle that holds a card clock rising edge |

## Verification
The assertions assume that software follows the rule of changing the divider code only while the clock is halted. Under that rule a running divide count never meets a shrinking terminal value, and bypass is never entered except from the halted state. The stimulus follows the rule: before each new divider code it writes a word with the enable bit clear and waits for the reference model to report the halted state. Only the enable bit, the auto-stop bit and bus_idle are toggled while the clock is running.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_BYPASS = 2'd2
    } sdclk_state_e;

    localparam int LO_CODE_BITS = 8;   // code bits 0..7: divide by 4..512
    localparam int POS_ENABLE   = 8;
    localparam int POS_AUTOSTOP = 9;
    localparam int POS_BYPASS   = 10;
    localparam int POS_SLOWEST  = 16;
    localparam int EXP_W        = 4;   // holds log2 of the divisor

endpackage

// File: rtl/sdclk_code_decode.sv
module sdclk_code_decode
    import sdclk_pkg::*;
#(
    parameter bit USE_DIV1024 = 1'b1
) (
    input  logic [LO_CODE_BITS-1:0] lo_code,
    input  logic                    bypass_bit,
    input  logic                    slow_bit,
    output logic [EXP_W-1:0]        div_exp,
    output logic                    bypass_sel
);

    logic [EXP_W-1:0] lo_exp [LO_CODE_BITS+1];
    logic             slow_en;

    assign slow_en   = USE_DIV1024 && slow_bit;
    assign lo_exp[0] = EXP_W'(1);

    // Ascending chain: a higher code bit overrides every lower one.
    generate
        for (genvar i = 0; i < LO_CODE_BITS; i++) begin : g_prio
            assign lo_exp[i+1] = lo_code[i] ? EXP_W'(i + 2) : lo_exp[i];
        end
    endgenerate

    assign div_exp    = slow_en ? EXP_W'(LO_CODE_BITS + 2) : lo_exp[LO_CODE_BITS];
    assign bypass_sel = bypass_bit && !slow_en && (lo_code == '0);

endmodule

// File: rtl/sdclk_phase_fsm.sv
module sdclk_phase_fsm
    import sdclk_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want,
    input  logic             bypass_sel,
    input  logic [EXP_W-1:0] div_exp,
    output sdclk_state_e     state,
    output logic             div_q,
    output logic             rise_stb
);

    sdclk_state_e     state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   half_v;
    logic [CNT_W-1:0] last_cnt;
    logic             terminal;
    logic             rise;
    logic             div_wanted;

    assign half_v     = {{CNT_W{1'b0}}, 1'b1} << (div_exp - EXP_W'(1));
    assign last_cnt   = CNT_W'(half_v - 1'b1);
    assign terminal   = (cnt_q >= last_cnt);
    assign div_wanted = want && !bypass_sel;

    always_comb begin
        rise = 1'b0;
        unique case (state)
            ST_HALT:   rise = div_wanted;
            ST_DIVIDE: rise = terminal && !div_q && div_wanted;
            ST_BYPASS: rise = 1'b0;
            default:   rise = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_HALT: begin
                if (want) state_d = bypass_sel ? ST_BYPASS : ST_DIVIDE;   // start-bypass / start-divide
            end
            ST_DIVIDE: begin
                if (terminal && !div_q && !div_wanted) state_d = ST_HALT; // park
            end
            ST_BYPASS: begin
                if (!(want && bypass_sel)) state_d = ST_HALT;             // leave-bypass
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            div_q    <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            rise_stb <= rise || (state == ST_BYPASS);
            unique case (state)
                ST_HALT: begin
                    cnt_q <= '0;
                    div_q <= rise;
                end
                ST_DIVIDE: begin
                    cnt_q <= terminal ? '0 : cnt_q + 1'b1;
                    if (terminal) div_q <= div_q ? 1'b0 : rise;
                end
                ST_BYPASS: begin
                    cnt_q <= '0;
                    div_q <= 1'b0;
                end
                default: begin
                    cnt_q <= '0;
                    div_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdclk_bypass_gate.sv
module sdclk_bypass_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req,
    output logic gated_clk
);

    logic gate_lo_q;

    // Sampled while clk is low, so the AND below never cuts a pulse.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_lo_q <= 1'b0;
        else        gate_lo_q <= gate_req;
    end

    assign gated_clk = clk & gate_lo_q;

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter bit USE_DIV1024 = 1'b1,
    parameter int REG_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             bus_idle,
    output logic             card_clk,
    output logic             rise_stb
);

    localparam int MAX_EXP = USE_DIV1024 ? LO_CODE_BITS + 2 : LO_CODE_BITS + 1;
    localparam int CNT_W   = MAX_EXP - 1;

    logic [LO_CODE_BITS-1:0] lo_code_q;
    logic                    bypass_q;
    logic                    slow_q;
    logic                    en_q;
    logic                    auto_q;
    logic [EXP_W-1:0]        div_exp;
    logic                    bypass_sel;
    logic                    want;
    sdclk_state_e            state;
    logic                    div_q;
    logic                    byp_clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_code_q <= '0;
            bypass_q  <= 1'b0;
            slow_q    <= 1'b0;
            en_q      <= 1'b0;
            auto_q    <= 1'b0;
        end else if (cfg_we) begin
            lo_code_q <= cfg_wdata[LO_CODE_BITS-1:0];
            bypass_q  <= cfg_wdata[POS_BYPASS];
            slow_q    <= cfg_wdata[POS_SLOWEST];
            en_q      <= cfg_wdata[POS_ENABLE];
            auto_q    <= cfg_wdata[POS_AUTOSTOP];
        end
    end

    assign want = en_q && !(auto_q && bus_idle);

    sdclk_code_decode #(.USE_DIV1024(USE_DIV1024)) u_decode (
        .lo_code    (lo_code_q),
        .bypass_bit (bypass_q),
        .slow_bit   (slow_q),
        .div_exp    (div_exp),
        .bypass_sel (bypass_sel)
    );

    sdclk_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .want       (want),
        .bypass_sel (bypass_sel),
        .div_exp    (div_exp),
        .state      (state),
        .div_q      (div_q),
        .rise_stb   (rise_stb)
    );

    sdclk_bypass_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_req  (state == ST_BYPASS),
        .gated_clk (byp_clk)
    );

    assign card_clk = div_q | byp_clk;

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
    import sdclk_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input sdclk_state_e state,
    input logic         div_q,
    input logic         rise_stb,
    input logic         en_q,
    input logic         auto_q,
    input logic         bus_idle,
    input logic         bypass_sel
);

    assert_rise_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIVIDE && $rose(div_q)) |-> rise_stb);

    assert_park_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && $past(state) == ST_DIVIDE) |-> !$past(div_q));

    assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !en_q) |=> (state == ST_HALT && !div_q));

    assert_bypass_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS && $past(state) == ST_HALT) |-> $past(bypass_sel));

    assert_idle_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && en_q && auto_q && bus_idle) |=> (state == ST_HALT));

endmodule

bind sdclk_gen sdclk_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .div_q      (div_q),
    .rise_stb   (rise_stb),
    .en_q       (en_q),
    .auto_q     (auto_q),
    .bus_idle   (bus_idle),
    .bypass_sel (bypass_sel)
);

// File: tb/sdclk_gen_test.sv
`timescale 1ns/1ps
module sdclk_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_idle = 1'b0;
    wire         card_clk;
    wire         rise_stb;

    always #2.5 clk = ~clk;   // 200 MHz

    sdclk_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .bus_idle  (bus_idle),
        .card_clk  (card_clk),
        .rise_stb  (rise_stb)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model: mode 0 = parked, 1 = dividing, 2 = pass-through
    int mmode = 0, mcnt = 0, mdiv = 2, mdq = 0, mstb = 0, mfast_prev = 0;
    bit men = 0, mauto = 0;

    function automatic int divisor_of(input logic [31:0] w);
        if (w[16]) return 1024;
        for (int i = 7; i >= 0; i--) if (w[i]) return 4 << i;
        if (w[10]) return 1;
        return 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mmode = 0; mcnt = 0; mdq = 0; mstb = 0; mfast_prev = 0;
            men = 0; mauto = 0; mdiv = 2;
        end else begin
            bit want;
            int half;
            want       = men && !(mauto && bus_idle);
            half       = (mdiv > 1) ? mdiv / 2 : 1;
            mfast_prev = (mmode == 2);
            mstb       = 0;
            case (mmode)
                0: begin
                    mcnt = 0; mdq = 0;
                    if (want) begin
                        if (mdiv == 1) mmode = 2;
                        else begin mmode = 1; mdq = 1; mstb = 1; end
                    end
                end
                1: begin
                    if (mcnt >= half - 1) begin
                        mcnt = 0;
                        if (mdq == 1) mdq = 0;
                        else if (want && mdiv != 1) begin mdq = 1; mstb = 1; end
                        else mmode = 0;
                    end else mcnt++;
                end
                default: begin
                    mstb = 1; mdq = 0; mcnt = 0;
                    if (!(want && mdiv == 1)) mmode = 0;
                end
            endcase
            if (cfg_we) begin
                men   = cfg_wdata[8];
                mauto = cfg_wdata[9];
                mdiv  = divisor_of(cfg_wdata);
            end
        end
        #1;
        if (rst_n && !done) begin
            int exp_clk;
            exp_clk = (mdq != 0 || mfast_prev != 0) ? 1 : 0;
            checks++;
            if (card_clk !== exp_clk[0]) begin
                errors++;
                $display("FAIL %s card_clk actual %0b expected %0b at %0t", cur_req, card_clk, exp_clk[0], $time);
            end
            checks++;
            if (rise_stb !== mstb[0]) begin
                errors++;
                $display("FAIL %s rise_stb actual %0b expected %0b at %0t", cur_req, rise_stb, mstb[0], $time);
            end
        end
    end

    task automatic write_reg(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic halt_clock();
        write_reg(32'h0);
        while (mmode != 0) @(negedge clk);
        run(2);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1;
        checks++;   // R1: outputs low while reset is held
        if (card_clk !== 1'b0 || rise_stb !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %0b%0b expected 00", card_clk, rise_stb);
        end
        run(3);
        rst_n = 1'b1;
        cur_req = "R1"; run(8);

        cur_req = "R2"; write_reg(32'h100); run(12); halt_clock();
        write_reg(32'h101); run(20); halt_clock();
        write_reg(32'h104); run(40); halt_clock();
        write_reg(32'h180); run(1100); halt_clock();
        cur_req = "R9"; write_reg(32'h102); run(30); halt_clock();

        cur_req = "R3"; write_reg(32'h500); run(10); halt_clock();
        cur_req = "R4"; write_reg(32'h10183); run(2100); halt_clock();
        cur_req = "R5"; write_reg(32'h106); run(40); halt_clock();
        write_reg(32'h501); run(20); halt_clock();

        cur_req = "R6"; write_reg(32'h003); run(20);
        write_reg(32'h400); run(10);

        cur_req = "R8"; write_reg(32'h104); run(11);
        write_reg(32'h004); run(30); halt_clock();

        cur_req = "R7"; write_reg(32'h302); run(20);
        bus_idle = 1'b1; run(20);
        bus_idle = 1'b0; run(20);
        bus_idle = 1'b1; run(3);
        bus_idle = 1'b0; run(20);
        halt_clock();

        cur_req = "R10"; bus_idle = 1'b1;
        write_reg(32'hFFFE_F902); run(30);
        bus_idle = 1'b0; halt_clock();

        finish_run();
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog expired actual running expected finished", cur_req);
            finish_run();
        end
    end

endmodule